// File: doc/BRIEF.md
# Activity-Gated Pipelined Word Selector

The block picks one of several data words per clock and presents it on a registered output. It keeps switching activity low: every data word has its own capture register, and that register loads only on the clock edge whose captured value will be forwarded to the output. Registers that no pending selection needs keep their contents, so their bits do not toggle.

The select code passes through two register stages. The first stage produces a one-hot load enable for the data capture registers. The second stage steers the output multiplexer. The enabled register is always the one that the second stage reads on the following edge. For this reason the output stream is identical, cycle for cycle, to a design in which every capture register loads on every edge. A select code that names no existing input is treated as input 0. Reset is synchronous and active high.

Top module: `actsel_top`

## Requirements
- R1: While reset is high, and on the first edge after reset is released, the output is zero. Reset clears the select stages, the capture registers and the output.
- R2: The select code sampled at clock edge e-2 decides which input appears at the output after edge e.
- R3: The data word that appears at the output after edge e is the word that was on the chosen input at clock edge e-1.
- R4: With eight inputs, select codes 0 through 7 choose input words 0 through 7 in that order. Word k occupies bits [8k+7:8k] of the data input.
- R5: A select code that is equal to or greater than the number of inputs chooses input word 0.
- R6: Capture register k loads only on an edge at which the first select stage holds code k, after folding by R5. On every other edge it keeps its value.
- R7: Exactly one capture register is enabled on every clock edge out of reset.
- R8: The output matches an ungated reference, in which every capture register loads on every edge, on every cycle and under any input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| selIn | input | SEL_W | Select code |
| dataIn | input | NUM_IN*DATA_W | Packed data words, word k in slice k |
| dataOut | output | DATA_W | Registered selected word |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the defaults (eight 8-bit inputs, 3-bit select), so every select code is valid and the full mapping is reachable. The other uses five inputs with the same 3-bit select, so codes 5 to 7 exercise the fallback to input 0 and the enable folding that goes with it. Both copies are compared every cycle against a reference that loads every input on every edge. The sequences change data while its input is not selected, alternate the select code every cycle, and apply a reset in the middle of a run.

// File: rtl/actsel_pkg.sv
package actsel_pkg;
  // Upper bounds for the control-to-datapath strobe bundle.
  localparam int MAX_IN = 16;
  localparam int IDX_W  = 4;

  typedef struct packed {
    logic [MAX_IN-1:0] loadEn;  // one-hot capture enable
    logic [IDX_W-1:0]  outSel;  // folded index read by the output mux
  } strobe_t;
endpackage

// File: rtl/actsel_ctrl.sv
module actsel_ctrl
  import actsel_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] selIn,
  output strobe_t          strobes
);
  logic [SEL_W-1:0]  selStage1;
  logic [SEL_W-1:0]  selStage2;
  logic [SEL_W-1:0]  loadSel;
  logic [SEL_W-1:0]  readSel;
  logic [MAX_IN-1:0] enVec;

  function automatic logic [SEL_W-1:0] foldSel(input logic [SEL_W-1:0] s);
    return (int'(s) < NUM_IN) ? s : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      selStage1 <= '0;
      selStage2 <= '0;
    end else begin
      selStage1 <= selIn;
      selStage2 <= selStage1;
    end
  end

  assign loadSel = foldSel(selStage1);
  assign readSel = foldSel(selStage2);

  // The stage-1 code becomes the stage-2 code on the next edge, and that
  // is the edge at which the mux reads the register enabled here.
  for (genvar k = 0; k < MAX_IN; k++) begin : g_en
    if (k < NUM_IN) begin : g_live
      assign enVec[k] = (loadSel == SEL_W'(k));
    end else begin : g_dead
      assign enVec[k] = 1'b0;
    end
  end

  always_comb begin
    strobes.loadEn = enVec;
    strobes.outSel = IDX_W'(readSel);
  end
endmodule

// File: rtl/actsel_dpath.sv
module actsel_dpath
  import actsel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_IN-1:0][DATA_W-1:0] dataIn,
  input  strobe_t                       strobes,
  output logic [NUM_IN-1:0][DATA_W-1:0] inRegQ,
  output logic [DATA_W-1:0]             dataOut
);
  logic [DATA_W-1:0] muxWord;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)                    inRegQ[k] <= '0;
      else if (strobes.loadEn[k]) inRegQ[k] <= dataIn[k];
    end
  end

  if (NUM_IN < MAX_IN) begin : g_spare
    logic unusedHighEn;
    assign unusedHighEn = ^strobes.loadEn[MAX_IN-1:NUM_IN];
  end

  // Word 0 is the default leg; the index arrives already folded.
  always_comb begin
    muxWord = inRegQ[0];
    for (int k = 1; k < NUM_IN; k++) begin
      if (strobes.outSel == IDX_W'(k)) muxWord = inRegQ[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= muxWord;
  end
endmodule

// File: rtl/actsel_top.sv
module actsel_top
  import actsel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8,   // at most MAX_IN and at most 2**SEL_W
  parameter int SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEL_W-1:0]              selIn,
  input  logic [NUM_IN-1:0][DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0]             dataOut
);
  strobe_t                       ctrlStrobes;
  logic [NUM_IN-1:0][DATA_W-1:0] inRegQ;

  actsel_ctrl #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .selIn(selIn), .strobes(ctrlStrobes)
  );

  actsel_dpath #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) u_dpath (
    .clk(clk), .rst(rst), .dataIn(dataIn), .strobes(ctrlStrobes),
    .inRegQ(inRegQ), .dataOut(dataOut)
  );
endmodule

// File: rtl/actsel_chk.sv
module actsel_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8,
  parameter int SEL_W  = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic [SEL_W-1:0]              selIn,
  input logic [NUM_IN-1:0][DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0]             dataOut,
  input logic [NUM_IN-1:0]             loadEn,
  input logic [NUM_IN-1:0][DATA_W-1:0] inRegQ
);
  logic [1:0]                    warm;
  logic [SEL_W-1:0]              selD1, selD2, selD3;
  logic [NUM_IN-1:0][DATA_W-1:0] dataD1, dataD2;
  logic [NUM_IN-1:0]             expEn;

  function automatic int foldIdx(input logic [SEL_W-1:0] s);
    return (int'(s) < NUM_IN) ? int'(s) : 0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
    selD1  <= selIn;
    selD2  <= selD1;
    selD3  <= selD2;
    dataD1 <= dataIn;
    dataD2 <= dataD1;
  end

  always_comb expEn = NUM_IN'(1) << foldIdx(selD1);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dataOut == '0); // R1

  AST_OUT_PIPE: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> dataOut == dataD2[foldIdx(selD3)]); // R2

  AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0) |-> loadEn == expEn); // R6

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $countones(loadEn) == 1); // R7

  for (genvar k = 0; k < NUM_IN; k++) begin : g_hold
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (warm != 2'd0 && !$past(loadEn[k])) |-> $stable(inRegQ[k])); // R6
  end
endmodule

bind actsel_top actsel_chk #(.DATA_W(DATA_W), .NUM_IN(NUM_IN), .SEL_W(SEL_W)) chk (
  .clk(clk), .rst(rst), .selIn(selIn), .dataIn(dataIn), .dataOut(dataOut),
  .loadEn(ctrlStrobes.loadEn[NUM_IN-1:0]), .inRegQ(inRegQ)
);

// File: tb/actsel_top_test.sv
`timescale 1ns/1ps
module actsel_top_test;
  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      selIn = '0;
  logic [7:0][7:0] dataBus = '0;
  logic [7:0]      outWide, outNarrow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  actsel_top uut (
    .clk(clk), .rst(rst), .selIn(selIn), .dataIn(dataBus), .dataOut(outWide)
  );

  actsel_top #(.NUM_IN(5)) uutNarrow (
    .clk(clk), .rst(rst), .selIn(selIn), .dataIn(dataBus[4:0]), .dataOut(outNarrow)
  );

  typedef struct {
    logic [7:0] wide;
    logic [7:0] narrow;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  // Ungated reference: every word captured on every edge.
  logic [7:0][7:0] prevData = '0;
  logic [2:0]      prevSel = '0, prevPrevSel = '0;

  function automatic int fold(input logic [2:0] s, input int n);
    return (int'(s) < n) ? int'(s) : 0;
  endfunction

  task automatic checkVal(input logic [7:0] act, input logic [7:0] exp, input string tag, input string who);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, who, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic driveCycle(input logic [2:0] s, input logic [7:0][7:0] d, input string tag);
    exp_t item;
    @(negedge clk);
    rst     = 1'b0;
    selIn   = s;
    dataBus = d;
    item.wide   = prevData[fold(prevPrevSel, 8)];
    item.narrow = prevData[fold(prevPrevSel, 5)];
    item.tag    = tag;
    expQ.push_back(item);
    prevPrevSel = prevSel;
    prevSel     = s;
    prevData    = d;
  endtask

  function automatic logic [7:0][7:0] randWords();
    logic [7:0][7:0] w;
    for (int j = 0; j < 8; j++) w[j] = 8'($urandom);
    return w;
  endfunction

  task automatic applyReset(input int cycles);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    dataBus = randWords();
    prevData = '0; prevSel = '0; prevPrevSel = '0;
    repeat (cycles) @(negedge clk);
    checkVal(outWide, 8'h00, "R1", "wide reset");
    checkVal(outNarrow, 8'h00, "R1", "narrow reset");
  endtask

  // Monitor: compares each expected item after the edge it belongs to.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checkVal(outWide, it.wide, it.tag, "wide");
        checkVal(outNarrow, it.narrow, it.tag, "narrow");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0][7:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkVal(outWide, 8'h00, "R1", "wide reset");
    checkVal(outNarrow, 8'h00, "R1", "narrow reset");

    // R4: every code in order, distinct words each cycle
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 8; j++) d[j] = 8'(16 * j + k);
      driveCycle(3'(k), d, "R4");
    end
    driveCycle(3'd0, '0, "R4");
    driveCycle(3'd0, '0, "R4");

    // R2: constant data, select changes every cycle
    for (int j = 0; j < 8; j++) d[j] = 8'(8'hA0 + j);
    foreach (d[i]) begin end
    driveCycle(3'd7, d, "R2");
    driveCycle(3'd0, d, "R2");
    driveCycle(3'd3, d, "R2");
    driveCycle(3'd3, d, "R2");
    driveCycle(3'd6, d, "R2");
    driveCycle(3'd1, d, "R2");

    // R3: constant select, data advancing every cycle
    for (int c = 0; c < 8; c++) begin
      for (int j = 0; j < 8; j++) d[j] = 8'(c * 8 + j + 1);
      driveCycle(3'd4, d, "R3");
    end

    // R5: codes beyond the narrow copy's range fold to word 0
    for (int c = 0; c < 9; c++) driveCycle(3'(5 + (c % 3)), randWords(), "R5");
    driveCycle(3'd2, randWords(), "R5");

    // R6: other words churn while word 2 stays selected, then switch
    for (int c = 0; c < 6; c++) driveCycle(3'd2, randWords(), "R6");
    driveCycle(3'd6, randWords(), "R6");
    driveCycle(3'd6, randWords(), "R6");
    driveCycle(3'd3, randWords(), "R6");

    // R7: alternate the select every cycle
    for (int c = 0; c < 10; c++) driveCycle((c % 2) ? 3'd6 : 3'd1, randWords(), "R7");

    // R1: reset in the middle of a run
    applyReset(2);
    driveCycle(3'd5, randWords(), "R1");
    driveCycle(3'd2, randWords(), "R1");

    // R8: long random run against the ungated reference
    for (int c = 0; c < 3000; c++) driveCycle(3'($urandom), randWords(), "R8");

    repeat (4) @(posedge clk);
    #1;
    finishRun();
  end
endmodule